// File: doc/BRIEF.md
# Packet Error Code Checker with Communication Fault Flags

This block watches the byte stream of a two-wire management bus target and runs a CRC-8 packet error code over every byte of a transaction: the address bytes with their read/write bit, the command byte, and the data bytes in both directions. For a host write it looks at the code the host may have put after the last data byte, and it decides at STOP whether the write may be carried out. For a read response the running code is on hand as the byte the target appends when the host clocks one more byte out.

A separate command decoder gives three inputs: whether the command code is supported (with the command byte), and, with STOP, how many data bytes the command takes and whether the data are legal. From the byte count the block knows whether the host added a code byte. A strict setting makes a code byte mandatory for writes. A wrong code, an unsupported command or bad data raises a communication fault. The fault sets a summary flag in the byte-wide and in the word-wide status view, and it sets a cause bit. These flags stay set until a clear pulse arrives.

Top module: `pec_guard`

## Requirements
- R1: `pec_out` is the CRC over all bytes taken since the START that opened the transaction, with polynomial x^8+x^2+x+1 (0x07), initial value 0x00, data fed MSB first, no final inversion. It changes on the cycle after a byte strobe. Bytes 0x31..0x39 give 0xF4, and the single byte 0x01 gives 0x07.
- R2: A START outside a transaction clears the code to 0x00. A START inside a transaction (repeated START) keeps it, and the address byte that follows is included.
- R3: After the device's read data, `pec_out` is the byte to append. Once that byte goes through the stream, `pec_out` reads 0x00.
- R4: A write has a supported command, `data_ok` high, a data-byte count equal to `exp_len`, and strict mode off. It gives `commit_stb` high for exactly one cycle, on the cycle after STOP.
- R5: A write with `exp_len`+1 data bytes carries a code byte. It commits only when the code matches. On a mismatch there is no commit, and cause bit 0 (code error) is set.
- R6: With `strict_pec` high at STOP, a write without a code byte does not commit and sets cause bit 0. A write with a correct code byte still commits.
- R7: A command byte taken while `cmd_known` is low makes the transaction, read or write, end without a commit and set cause bit 1 (unsupported command).
- R8: A supported write with `data_ok` low at STOP, or with a data count that is neither `exp_len` nor `exp_len`+1, does not commit and sets cause bit 2 (bad data). A length error takes precedence over a code check.
- R9: Any cause bit that gets set also sets `stat_byte_cml` and `stat_word_cml`. All of them stay set until a `clr_status` pulse. A new fault in the same cycle as the clear wins. The reset value of every output is 0.
- R10: Bytes and STOPs outside a transaction are ignored. A transaction that ends before its command byte neither commits nor faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_start | input | 1 | One-cycle pulse: START or repeated START seen |
| evt_stop | input | 1 | One-cycle pulse: STOP seen |
| byte_stb | input | 1 | One-cycle pulse: a byte was transferred |
| byte_dat | input | 8 | Byte transferred, valid with byte_stb |
| cmd_known | input | 1 | Command code supported, sampled with the command byte |
| data_ok | input | 1 | Write data legal, sampled with evt_stop |
| exp_len | input | LEN_W | Data bytes the command takes, sampled with evt_stop |
| strict_pec | input | 1 | Writes need a code byte, sampled with evt_stop |
| clr_status | input | 1 | Clears all fault flags |
| commit_stb | output | 1 | One-cycle pulse: write may be carried out |
| pec_out | output | 8 | Running packet error code |
| stat_byte_cml | output | 1 | Communication fault flag, byte-wide status view |
| stat_word_cml | output | 1 | Communication fault flag, word-wide status view |
| cml_cause | output | 3 | Cause bits: 0 code error, 1 unsupported command, 2 bad data |

## Verification
A corrupted code register shows up on `pec_out` on the cycle after the bad byte. It also turns a correct write into a code fault at the next STOP. A byte-role tracker that is wrong after a repeated START misplaces the data count, so the fault flags or a missing `commit_stb` show the error one cycle after STOP. A cause bit that fails to latch, or that clears by itself, differs from the model on the first clock in which it should have held. This is why the outputs are compared on every cycle rather than only at transaction ends.

// File: rtl/pec_pkg.sv
// Shared types for the packet error code checker.
// Assumes: cause bit positions are fixed by software view (0 code, 1 cmd, 2 data).
package pec_pkg;
    localparam int CRC_W = 8;

    typedef struct packed {
        logic bad_data;   // bit 2
        logic bad_cmd;    // bit 1
        logic pec_err;    // bit 0
    } cml_cause_t;

    localparam int CAUSE_W = $bits(cml_cause_t);
endpackage

// File: rtl/pec_crc8.sv
// Running CRC over a byte stream, one whole byte per cycle, MSB first.
// Assumes: restart and update never come in the same cycle (restart wins).
module pec_crc8 #(
    parameter logic [7:0] POLY = 8'h07
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       update,
    input  logic [7:0] din,
    output logic [7:0] crc
);
    localparam int NBITS = 8;

    logic [NBITS:0][7:0] stage;

    assign stage[0] = crc;

    // One shift-and-feedback step per input bit, MSB first.
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        logic fb;
        assign fb = stage[i][7] ^ din[NBITS-1-i];
        assign stage[i+1] = {stage[i][6:0], 1'b0} ^ (fb ? POLY : 8'h00);
    end

    // Register the code: clear on a fresh transaction, advance on a byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       crc <= 8'h00;
        else if (restart) crc <= 8'h00;
        else if (update)  crc <= stage[NBITS];
    end
endmodule

// File: rtl/pec_txn_track.sv
// Tracks transaction framing and byte roles: address, command, write data.
// Assumes: start, stop and byte strobes are single-cycle; stop wins over start.
module pec_txn_track #(
    parameter int LEN_W = 4,
    localparam int CNT_W = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_start,
    input  logic             evt_stop,
    input  logic             byte_stb,
    input  logic             addr_rw,
    input  logic             cmd_known,
    output logic             in_txn,
    output logic             cmd_seen,
    output logic             cmd_ok,
    output logic             is_read,
    output logic [CNT_W-1:0] data_cnt,
    output logic             open_start,
    output logic             byte_take
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic addr_next;

    assign open_start = evt_start && !evt_stop && !in_txn;
    assign byte_take  = byte_stb && in_txn && !evt_start && !evt_stop;

    // Update framing state and classify each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_txn    <= 1'b0;
            addr_next <= 1'b0;
            cmd_seen  <= 1'b0;
            cmd_ok    <= 1'b0;
            is_read   <= 1'b0;
            data_cnt  <= '0;
        end else if (evt_stop) begin
            in_txn    <= 1'b0;
            addr_next <= 1'b0;
            cmd_seen  <= 1'b0;
            cmd_ok    <= 1'b0;
            is_read   <= 1'b0;
            data_cnt  <= '0;
        end else if (evt_start) begin
            in_txn    <= 1'b1;
            addr_next <= 1'b1;
            if (!in_txn) begin
                cmd_seen <= 1'b0;
                cmd_ok   <= 1'b0;
                is_read  <= 1'b0;
                data_cnt <= '0;
            end
        end else if (byte_take) begin
            if (addr_next) begin
                addr_next <= 1'b0;
                if (addr_rw) is_read <= 1'b1;
            end else if (!cmd_seen) begin
                cmd_seen <= 1'b1;
                cmd_ok   <= cmd_known;
            end else if (!is_read && data_cnt != CNT_MAX) begin
                data_cnt <= data_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pec_verdict.sv
// Decides at STOP whether a write commits or which fault cause to raise.
// Assumes: the CRC residue over data plus a correct code byte is zero.
module pec_verdict
    import pec_pkg::*;
#(
    parameter int LEN_W = 4,
    localparam int CNT_W = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_stop,
    input  logic             in_txn,
    input  logic             cmd_seen,
    input  logic             cmd_ok,
    input  logic             is_read,
    input  logic [CNT_W-1:0] data_cnt,
    input  logic [LEN_W-1:0] exp_len,
    input  logic             data_ok,
    input  logic             strict_pec,
    input  logic [7:0]       crc,
    output logic             commit_stb,
    output cml_cause_t       cause_set
);
    logic [CNT_W-1:0] exp_ext;
    logic [CNT_W-1:0] exp_p1;
    logic             len_plain;
    logic             len_pec;
    logic             len_bad;
    logic             crc_zero;
    logic             pec_bad;
    logic             commit_d;

    assign exp_ext   = {1'b0, exp_len};
    assign exp_p1    = exp_ext + 1'b1;
    assign len_plain = (data_cnt == exp_ext);
    assign len_pec   = (data_cnt == exp_p1);
    assign len_bad   = !(len_plain || len_pec);
    assign crc_zero  = (crc == 8'h00);
    assign pec_bad   = !len_bad && ((len_pec && !crc_zero) || (len_plain && strict_pec));

    // Resolve the end-of-transaction outcome with fixed cause precedence.
    always_comb begin
        cause_set = '0;
        commit_d  = 1'b0;
        if (evt_stop && in_txn && cmd_seen) begin
            if (!cmd_ok)             cause_set.bad_cmd  = 1'b1;
            else if (!is_read) begin
                if (len_bad)         cause_set.bad_data = 1'b1;
                else if (pec_bad)    cause_set.pec_err  = 1'b1;
                else if (!data_ok)   cause_set.bad_data = 1'b1;
                else                 commit_d           = 1'b1;
            end
        end
    end

    // Register the commit pulse one cycle after STOP.
    always_ff @(posedge clk) begin
        if (!rst_n) commit_stb <= 1'b0;
        else        commit_stb <= commit_d;
    end
endmodule

// File: rtl/pec_status.sv
// Sticky communication fault flags with cause bits; set wins over clear.
// Assumes: cause_set is a single-cycle pulse vector.
module pec_status
    import pec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  cml_cause_t cause_set,
    output cml_cause_t cause,
    output logic       stat_byte,
    output logic       stat_word
);
    logic any_set;

    assign any_set = |cause_set;

    // Latch cause bits until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)   cause <= '0;
        else if (clr) cause <= cause_set;
        else          cause <= cause | cause_set;
    end

    // Latch the summary flag for both status views.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_byte <= 1'b0;
            stat_word <= 1'b0;
        end else begin
            if (any_set)  stat_byte <= 1'b1;
            else if (clr) stat_byte <= 1'b0;
            if (any_set)  stat_word <= 1'b1;
            else if (clr) stat_word <= 1'b0;
        end
    end
endmodule

// File: rtl/pec_guard.sv
// Top: packet error code checking, write gating and fault flagging.
// Assumes: an external decoder supplies cmd_known, exp_len and data_ok.
module pec_guard
    import pec_pkg::*;
#(
    parameter int         LEN_W = 4,
    parameter logic [7:0] POLY  = 8'h07
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_start,
    input  logic             evt_stop,
    input  logic             byte_stb,
    input  logic [7:0]       byte_dat,
    input  logic             cmd_known,
    input  logic             data_ok,
    input  logic [LEN_W-1:0] exp_len,
    input  logic             strict_pec,
    input  logic             clr_status,
    output logic             commit_stb,
    output logic [7:0]       pec_out,
    output logic             stat_byte_cml,
    output logic             stat_word_cml,
    output logic [2:0]       cml_cause
);
    localparam int CNT_W = LEN_W + 1;

    logic             in_txn;
    logic             cmd_seen;
    logic             cmd_ok;
    logic             is_read;
    logic [CNT_W-1:0] data_cnt;
    logic             open_start;
    logic             byte_take;
    cml_cause_t       cause_set;
    cml_cause_t       cause_q;

    pec_txn_track #(.LEN_W(LEN_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_start  (evt_start),
        .evt_stop   (evt_stop),
        .byte_stb   (byte_stb),
        .addr_rw    (byte_dat[0]),
        .cmd_known  (cmd_known),
        .in_txn     (in_txn),
        .cmd_seen   (cmd_seen),
        .cmd_ok     (cmd_ok),
        .is_read    (is_read),
        .data_cnt   (data_cnt),
        .open_start (open_start),
        .byte_take  (byte_take)
    );

    pec_crc8 #(.POLY(POLY)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (open_start),
        .update  (byte_take),
        .din     (byte_dat),
        .crc     (pec_out)
    );

    pec_verdict #(.LEN_W(LEN_W)) u_verdict (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_stop   (evt_stop),
        .in_txn     (in_txn),
        .cmd_seen   (cmd_seen),
        .cmd_ok     (cmd_ok),
        .is_read    (is_read),
        .data_cnt   (data_cnt),
        .exp_len    (exp_len),
        .data_ok    (data_ok),
        .strict_pec (strict_pec),
        .crc        (pec_out),
        .commit_stb (commit_stb),
        .cause_set  (cause_set)
    );

    pec_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_status),
        .cause_set (cause_set),
        .cause     (cause_q),
        .stat_byte (stat_byte_cml),
        .stat_word (stat_word_cml)
    );

    assign cml_cause = cause_q;
endmodule

// File: rtl/pec_guard_chk.sv
// Checker for pec_guard: temporal properties on ports and framing state.
// Assumes: bound to every pec_guard instance.
module pec_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       evt_start,
    input logic       evt_stop,
    input logic       clr_status,
    input logic       strict_pec,
    input logic       in_txn,
    input logic       commit_stb,
    input logic [7:0] pec_out,
    input logic [2:0] cml_cause,
    input logic       stat_byte_cml,
    input logic       stat_word_cml
);
    // R2: an opening START leaves a zero code behind.
    assert_open_start_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_start && !evt_stop && !in_txn) |=> (pec_out == 8'h00));

    // R4: commit is a single-cycle pulse following a STOP.
    assert_commit_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |-> $past(evt_stop));
    assert_commit_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |=> !commit_stb);

    // R6: a strict-mode commit only follows a zero residue.
    assert_strict_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_stb && $past(strict_pec)) |-> ($past(pec_out) == 8'h00));

    // R5: a commit never coincides with a new fault cause.
    assert_commit_no_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_stb && !$past(clr_status)) |-> $stable(cml_cause));

    // R9: cause bits only fall after a clear, and only rise after a STOP.
    assert_cause_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr_status) |-> (($past(cml_cause) & ~cml_cause) == 3'b000));
    assert_cause_at_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((cml_cause & ~$past(cml_cause)) != 3'b000) |-> $past(evt_stop));
    assert_views_agree_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_byte_cml == stat_word_cml) && (stat_byte_cml == (cml_cause != 3'b000)));
endmodule

bind pec_guard pec_guard_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_start     (evt_start),
    .evt_stop      (evt_stop),
    .clr_status    (clr_status),
    .strict_pec    (strict_pec),
    .in_txn        (in_txn),
    .commit_stb    (commit_stb),
    .pec_out       (pec_out),
    .cml_cause     (cml_cause),
    .stat_byte_cml (stat_byte_cml),
    .stat_word_cml (stat_word_cml)
);

// File: tb/sim_pec_guard.sv
module sim_pec_guard;
    localparam int LEN_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             evt_start = 1'b0;
    logic             evt_stop = 1'b0;
    logic             byte_stb = 1'b0;
    logic [7:0]       byte_dat = 8'h00;
    logic             cmd_known = 1'b1;
    logic             data_ok = 1'b1;
    logic [LEN_W-1:0] exp_len = '0;
    logic             strict_pec = 1'b0;
    logic             clr_status = 1'b0;
    logic             commit_stb;
    logic [7:0]       pec_out;
    logic             stat_byte_cml;
    logic             stat_word_cml;
    logic [2:0]       cml_cause;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;   // 50 MHz

    pec_guard #(.LEN_W(LEN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .evt_stop(evt_stop),
        .byte_stb(byte_stb), .byte_dat(byte_dat), .cmd_known(cmd_known),
        .data_ok(data_ok), .exp_len(exp_len), .strict_pec(strict_pec),
        .clr_status(clr_status), .commit_stb(commit_stb), .pec_out(pec_out),
        .stat_byte_cml(stat_byte_cml), .stat_word_cml(stat_word_cml),
        .cml_cause(cml_cause)
    );

    function automatic logic [7:0] crc8(input logic [7:0] q[$]);
        logic [7:0] c = 8'h00;
        foreach (q[i]) begin
            c ^= q[i];
            for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c;
    endfunction

    // Behavioural reference model, advanced at each rising edge.
    logic [7:0] m_q[$];
    logic [7:0] m_crc = 0;
    bit   m_in = 0, m_first = 0, m_cmd = 0, m_cmdok = 0, m_read = 0, m_commit = 0;
    int   m_cnt = 0;
    logic [2:0] m_cause = 0;

    always @(posedge clk) begin
        logic [2:0] set;
        set = 3'b000;
        m_commit = 0;
        if (!rst_n) begin
            m_q = {}; m_crc = 0; m_in = 0; m_first = 0; m_cmd = 0;
            m_cmdok = 0; m_read = 0; m_cnt = 0; m_cause = 0;
        end else begin
            if (evt_stop) begin
                if (m_in && m_cmd) begin
                    if (!m_cmdok) set[1] = 1;
                    else if (!m_read) begin
                        if (m_cnt != exp_len && m_cnt != exp_len + 1) set[2] = 1;
                        else if ((m_cnt == exp_len + 1 && m_crc != 0) ||
                                 (m_cnt == exp_len && strict_pec)) set[0] = 1;
                        else if (!data_ok) set[2] = 1;
                        else m_commit = 1;
                    end
                end
                m_in = 0; m_first = 0; m_cmd = 0; m_read = 0; m_cnt = 0;
            end else if (evt_start) begin
                if (!m_in) begin
                    m_q = {}; m_crc = 0; m_cmd = 0; m_read = 0; m_cnt = 0;
                end
                m_in = 1; m_first = 1;
            end else if (byte_stb && m_in) begin
                m_q.push_back(byte_dat);
                m_crc = crc8(m_q);
                if (m_first) begin m_first = 0; if (byte_dat[0]) m_read = 1; end
                else if (!m_cmd) begin m_cmd = 1; m_cmdok = cmd_known; end
                else if (!m_read) m_cnt++;
            end
            if (clr_status) m_cause = 0;
            m_cause |= set;
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_tests++;
            if (pec_out !== m_crc) begin
                n_fail++; $display("FAIL R1 model pec_out act=%02h exp=%02h", pec_out, m_crc);
            end
            n_tests++;
            if (commit_stb !== m_commit) begin
                n_fail++; $display("FAIL R4 model commit act=%0b exp=%0b", commit_stb, m_commit);
            end
            n_tests++;
            if (cml_cause !== m_cause || stat_byte_cml !== (m_cause != 0) ||
                stat_word_cml !== (m_cause != 0)) begin
                n_fail++;
                $display("FAIL R9 model status act=%03b/%0b/%0b exp=%03b", cml_cause,
                         stat_byte_cml, stat_word_cml, m_cause);
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
        end
    endtask

    logic [7:0] tq[$];

    task automatic t_start;
        evt_start = 1; @(negedge clk); evt_start = 0;
    endtask
    task automatic t_byte(input logic [7:0] b, input bit known = 1);
        byte_stb = 1; byte_dat = b; cmd_known = known; tq.push_back(b);
        @(negedge clk); byte_stb = 0; cmd_known = 1;
    endtask
    task automatic t_stop(input int n, input bit ok = 1, input bit clr = 0);
        exp_len = n[LEN_W-1:0]; data_ok = ok; evt_stop = 1; clr_status = clr;
        @(negedge clk); evt_stop = 0; clr_status = 0; data_ok = 1;
    endtask
    task automatic t_clear;
        clr_status = 1; @(negedge clk); clr_status = 0;
    endtask
    // pec_mode: 0 none, 1 correct code byte, 2 corrupted code byte
    task automatic t_write(input bit known, input int nd, input int pec_mode,
                           input int explen, input bit ok = 1, input bit clr = 0);
        tq = {};
        t_start;
        t_byte(8'hA6);
        t_byte(8'h5C, known);
        for (int i = 0; i < nd; i++) t_byte(8'(i * 17 + 3));
        if (pec_mode == 1) t_byte(crc8(tq));
        else if (pec_mode == 2) t_byte(crc8(tq) ^ 8'h01);
        t_stop(explen, ok, clr);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] hold;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9: reset state
        chk("R9 reset pec_out", pec_out, 8'h00);
        chk("R9 reset commit", {7'd0, commit_stb}, 8'h00);
        chk("R9 reset cause", {5'd0, cml_cause}, 8'h00);

        // R1, R10: single byte 0x01 -> 0x07; no command byte so nothing happens
        t_start; t_byte(8'h01);
        chk("R1 crc of 0x01", pec_out, 8'h07);
        t_stop(0);
        chk("R10 short txn no fault", {5'd0, cml_cause}, 8'h00);
        chk("R10 short txn no commit", {7'd0, commit_stb}, 8'h00);

        // R1: check string "123456789" -> 0xF4
        t_start;
        for (int i = 0; i < 9; i++) t_byte(8'h31 + 8'(i));
        chk("R1 check string", pec_out, 8'hF4);
        t_stop(0);

        // R2, R3: write address, command, repeated START, read address, device data
        tq = {};
        t_start; t_byte(8'hA6); t_byte(8'h21);
        t_start; t_byte(8'hA7); t_byte(8'h10); t_byte(8'h20);
        chk("R2 repeated start keeps code", pec_out, crc8(tq));
        t_byte(pec_out);
        chk("R3 appended code gives zero", pec_out, 8'h00);
        t_stop(0);
        chk("R3 read no commit", {7'd0, commit_stb}, 8'h00);

        // R2: new opening START clears code
        t_start;
        chk("R2 opening start clears", pec_out, 8'h00);
        t_stop(0);

        // R4: plain write commits, single cycle
        t_write(1, 2, 0, 2);
        chk("R4 plain write commit", {7'd0, commit_stb}, 8'h01);
        @(negedge clk);
        chk("R4 commit single cycle", {7'd0, commit_stb}, 8'h00);

        // R5: correct code commits, corrupted code faults
        t_write(1, 3, 1, 3);
        chk("R5 good code commit", {7'd0, commit_stb}, 8'h01);
        t_write(1, 3, 2, 3);
        chk("R5 bad code no commit", {7'd0, commit_stb}, 8'h00);
        chk("R5 bad code cause", {5'd0, cml_cause}, 8'h01);
        chk("R9 byte flag", {7'd0, stat_byte_cml}, 8'h01);
        chk("R9 word flag", {7'd0, stat_word_cml}, 8'h01);
        @(negedge clk);
        chk("R9 cause held", {5'd0, cml_cause}, 8'h01);
        t_clear;
        chk("R9 cleared", {5'd0, cml_cause}, 8'h00);
        chk("R9 flag cleared", {7'd0, stat_byte_cml}, 8'h00);

        // R6: strict mode
        strict_pec = 1;
        t_write(1, 1, 0, 1);
        chk("R6 strict missing code", {7'd0, commit_stb}, 8'h00);
        chk("R6 strict cause", {5'd0, cml_cause}, 8'h01);
        t_clear;
        t_write(1, 1, 1, 1);
        chk("R6 strict good code commit", {7'd0, commit_stb}, 8'h01);
        strict_pec = 0;

        // R7: unsupported command on write and on read
        t_write(0, 1, 0, 1);
        chk("R7 write unsupported no commit", {7'd0, commit_stb}, 8'h00);
        chk("R7 write unsupported cause", {5'd0, cml_cause}, 8'h02);
        t_clear;
        t_start; t_byte(8'hA6); t_byte(8'h44, 0);
        t_start; t_byte(8'hA7); t_byte(8'h99);
        t_stop(0);
        chk("R7 read unsupported cause", {5'd0, cml_cause}, 8'h02);
        t_clear;

        // R8: bad data flag and bad length (length wins over code)
        t_write(1, 2, 1, 2, 0);
        chk("R8 data_ok low no commit", {7'd0, commit_stb}, 8'h00);
        chk("R8 data_ok low cause", {5'd0, cml_cause}, 8'h04);
        t_clear;
        t_write(1, 1, 2, 4);
        chk("R8 length wrong cause", {5'd0, cml_cause}, 8'h04);

        // R9: fault arriving with a clear wins
        t_write(1, 2, 2, 2, 1, 1);
        chk("R9 set beats clear", {5'd0, cml_cause}, 8'h01);
        t_clear;

        // R10: bytes and stop outside a transaction are ignored
        hold = pec_out;
        t_byte(8'h55); t_byte(8'hAA);
        chk("R10 stray bytes ignored", pec_out, hold);
        t_stop(0);
        chk("R10 stray stop no commit", {7'd0, commit_stb}, 8'h00);
        chk("R10 stray stop no fault", {5'd0, cml_cause}, 8'h00);

        repeat (3) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule